// File: doc/BRIEF.md
# Two-stage watchdog timer

This block watches for software that stops running. An 18-bit up-counter advances once per watchdog tick, which is a single-cycle enable from a slower clock domain's divider. When the count reaches a selectable power-of-two interval, the block raises a time-out flag and opens a grace window. Software must restart the counter within that window. If it does not, and resets are enabled, the block sends a one-cycle system reset request.

Software reaches the block through a small synchronous register port. A control word sits at byte offset 0x0 and a grace-length word at 0x4. Most configuration bits can be written only while the protection-open input is high. The three status flags are cleared by writing 1. A configuration input from outside the block can force the watchdog on, so that software cannot switch it off. A debug-halt input pauses counting unless software has asked the watchdog to keep running during debug.

After a reset request the block clears its own counter and grace logic and records the event in a flag. Its state therefore stays observable without an actual chip reset.

Top module: `wdog_top`

## Requirements
- R1: Writing control bit 0 as 1 while `prot_open` is high restarts the count from zero and ends any open grace window. Bit 0 always reads 0.
- R2: The control field at bits 10:8 holds a code k from 0 to 7. The time-out flag (control bit 3) sets on the 2^(4+2k)-th active tick after a restart, and not on any earlier tick.
- R3: `irq_o` is high exactly while the time-out flag and the interrupt enable (control bit 6) are both 1.
- R4: After a time-out, the grace length is selected by bits 1:0 at offset 0x4: code 0 gives 1026 active ticks, code 1 gives 130, code 2 gives 18 and code 3 gives 3. If reset enable (control bit 1) is 1 and no restart comes within that many ticks, `rst_req_o` pulses high for exactly one cycle after the last tick. A restart inside the window, or reset enable at 0, produces no pulse.
- R5: A reset request does three things: it sets the reset flag (control bit 2), it returns the grace-length field at 0x4 to 0, and it restarts the count from zero.
- R6: The reset flag and the time-out flag are cleared by writing 1 to their bits, whatever the level of `prot_open`. The wake flag (control bit 5) is cleared by writing 1 only while `prot_open` is high. Writing 0 to any flag leaves it unchanged.
- R7: A time-out sets the wake flag and pulses `wake_o` for one cycle only when wake enable (control bit 4) and interrupt enable are both 1. Otherwise neither happens.
- R8: When control bit 7 reads 0, the counter is held at zero and no time-out occurs. When `force_cfg` is not 3'b111, bit 7 reads 1 and the watchdog runs, even after a 0 has been written to it.
- R9: While `dbg_halt` is high and control bit 31 is 0, ticks do not advance the count. While bit 31 is 1, ticks advance the count regardless of `dbg_halt`.
- R10: While `prot_open` is low, writes leave control bits 0, 1, 4, 5, 6, 7, 10:8 and 31 and the grace-length field unchanged. A restart is not triggered.
- R11: After reset, with `force_cfg` at 3'b111, both registers read 0. All bits other than those named above read 0, and addresses other than 0x0 and 0x4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_tick | input | 1 | One-cycle watchdog tick enable |
| reg_addr | input | ADDR_W | Byte address of the register port |
| reg_we | input | 1 | Write strobe, acts at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| prot_open | input | 1 | High to open protected bits for writing |
| dbg_halt | input | 1 | CPU held in debug |
| force_cfg | input | 3 | Any value other than 3'b111 forces the watchdog on |
| irq_o | output | 1 | Time-out interrupt |
| wake_o | output | 1 | One-cycle wake-up trigger |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A count that has slipped shows up as a time-out flag that sets one tick early or late relative to the restart. A boundary check at tick 2^(4+2k)-1 and at tick 2^(4+2k) catches the error on the very first interval. A grace counter that is off by one, or that misses a restart, moves or produces the reset pulse, and a pulse monitor sees this within the window's length. A lock or flag-priority error shows up on the next read of the control word.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  parameter int CNT_W = 18;
  parameter int DLY_W = 11;

  typedef struct packed {
    logic       run_in_dbg;
    logic [2:0] tsel;
    logic       en;
    logic       rsten;
  } wd_ctl_t;

  // last counter value before time-out: 2^(4+2*sel) - 1
  function automatic logic [CNT_W-1:0] tmo_last(input logic [2:0] sel);
    logic [CNT_W:0] span;
    span = {{CNT_W{1'b0}}, 1'b1} << (5'd4 + {1'b0, sel, 1'b0});
    return span[CNT_W-1:0] - 1'b1;
  endfunction

  // last grace-window tick index for each grace code
  function automatic logic [DLY_W-1:0] dly_last(input logic [1:0] sel);
    case (sel)
      2'd0:    return DLY_W'(1025);
      2'd1:    return DLY_W'(129);
      2'd2:    return DLY_W'(17);
      default: return DLY_W'(2);
    endcase
  endfunction

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       dbg_halt_i,
  input  logic       restart_i,
  input  wd_ctl_t    ctl_i,
  input  logic [1:0] dsel_i,
  output logic       tmo_o,
  output logic       rst_req_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] dcnt_q, dcnt_d;
  logic             armed_q, armed_d;
  logic             rreq_q, rreq_d;
  logic             active, at_lim, at_dly;

  assign active = tick_i & ctl_i.en & ~(dbg_halt_i & ~ctl_i.run_in_dbg);
  assign at_lim = (cnt_q == tmo_last(ctl_i.tsel));
  assign at_dly = (dcnt_q >= dly_last(dsel_i));
  assign tmo_o  = active & at_lim & ~restart_i;

  always_comb begin
    cnt_d   = cnt_q;
    dcnt_d  = dcnt_q;
    armed_d = armed_q;
    rreq_d  = 1'b0;
    if (!ctl_i.en || restart_i) begin
      cnt_d   = '0;
      dcnt_d  = '0;
      armed_d = 1'b0;
    end else if (active) begin
      cnt_d = at_lim ? '0 : cnt_q + 1'b1;
      if (armed_q) begin
        if (at_dly) begin
          armed_d = 1'b0;
          dcnt_d  = '0;
          if (ctl_i.rsten) begin
            rreq_d = 1'b1;
            cnt_d  = '0;
          end
        end else begin
          dcnt_d = dcnt_q + 1'b1;
        end
      end else if (at_lim) begin
        armed_d = 1'b1;
        dcnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      dcnt_q  <= '0;
      armed_q <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      dcnt_q  <= dcnt_d;
      armed_q <= armed_d;
      rreq_q  <= rreq_d;
    end
  end

  assign rst_req_o = rreq_q;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rst_req_o |=> !rst_req_o); // R4
  AST_RST_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) rst_req_o |-> $past(armed_q)); // R4
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) restart_i |=> (cnt_q == '0) && !armed_q); // R1
  AST_RST_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) rst_req_o |-> (cnt_q == '0) && !armed_q); // R5
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !ctl_i.en |=> (cnt_q == '0) && !rst_req_o); // R8
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (ctl_i.en && dbg_halt_i && !ctl_i.run_in_dbg && !restart_i) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              prot_open_i,
  input  logic [2:0]        force_cfg_i,
  input  logic              tmo_i,
  input  logic              rst_req_i,
  output logic [31:0]       rdata_o,
  output logic              restart_o,
  output wd_ctl_t           ctl_o,
  output logic [1:0]        dsel_o,
  output logic              irq_o,
  output logic              wake_o
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ALT_ADDR  = ADDR_W'(4);

  logic       rsten_q, rsten_d, wken_q, wken_d, inten_q, inten_d;
  logic       en_q, en_d, run_q, run_d;
  logic [2:0] tsel_q, tsel_d;
  logic [1:0] dsel_q, dsel_d;
  logic       rstf_q, rstf_d, if_q, if_d, wkf_q, wkf_d, wake_q, wake_d;
  logic       wr_ctrl, wr_ctrl_lk, wr_alt_lk, forced, en_eff, wake_ev;
  logic       wdata_unused;

  assign wdata_unused = ^wdata_i[30:11];
  assign wr_ctrl    = we_i & (addr_i == CTRL_ADDR);
  assign wr_ctrl_lk = wr_ctrl & prot_open_i;
  assign wr_alt_lk  = we_i & (addr_i == ALT_ADDR) & prot_open_i;
  assign forced     = (force_cfg_i != 3'b111);
  assign en_eff     = en_q | forced;
  assign wake_ev    = tmo_i & wken_q & inten_q;

  always_comb begin
    rsten_d = rsten_q;
    wken_d  = wken_q;
    inten_d = inten_q;
    en_d    = en_q;
    run_d   = run_q;
    tsel_d  = tsel_q;
    if (wr_ctrl_lk) begin
      rsten_d = wdata_i[1];
      wken_d  = wdata_i[4];
      inten_d = wdata_i[6];
      en_d    = wdata_i[7];
      tsel_d  = wdata_i[10:8];
      run_d   = wdata_i[31];
    end
    if (rst_req_i)      dsel_d = 2'd0;
    else if (wr_alt_lk) dsel_d = wdata_i[1:0];
    else                dsel_d = dsel_q;
    if_d   = tmo_i | (if_q & ~(wr_ctrl & wdata_i[3]));
    rstf_d = rst_req_i | (rstf_q & ~(wr_ctrl & wdata_i[2]));
    wkf_d  = wake_ev | (wkf_q & ~(wr_ctrl_lk & wdata_i[5]));
    wake_d = wake_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsten_q <= 1'b0;
      wken_q  <= 1'b0;
      inten_q <= 1'b0;
      en_q    <= 1'b0;
      run_q   <= 1'b0;
      tsel_q  <= 3'd0;
      dsel_q  <= 2'd0;
      rstf_q  <= 1'b0;
      if_q    <= 1'b0;
      wkf_q   <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      rsten_q <= rsten_d;
      wken_q  <= wken_d;
      inten_q <= inten_d;
      en_q    <= en_d;
      run_q   <= run_d;
      tsel_q  <= tsel_d;
      dsel_q  <= dsel_d;
      rstf_q  <= rstf_d;
      if_q    <= if_d;
      wkf_q   <= wkf_d;
      wake_q  <= wake_d;
    end
  end

  always_comb begin
    if (addr_i == CTRL_ADDR)
      rdata_o = {run_q, 20'd0, tsel_q, en_eff, inten_q, wkf_q, wken_q,
                 if_q, rstf_q, rsten_q, 1'b0};
    else if (addr_i == ALT_ADDR)
      rdata_o = {30'd0, dsel_q};
    else
      rdata_o = 32'd0;
  end

  assign restart_o = wr_ctrl_lk & wdata_i[0];
  assign ctl_o     = '{run_in_dbg: run_q, tsel: tsel_q, en: en_eff, rsten: rsten_q};
  assign dsel_o    = dsel_q;
  assign irq_o     = if_q & inten_q;
  assign wake_o    = wake_q;

  AST_FLAG_ON_TMO: assert property (@(posedge clk) disable iff (!rst_n) tmo_i |=> if_q); // R2
  AST_RSTF_ON_RST: assert property (@(posedge clk) disable iff (!rst_n) rst_req_i |=> rstf_q && (dsel_q == 2'd0)); // R5
  AST_LOCK_CTRL: assert property (@(posedge clk) disable iff (!rst_n) !prot_open_i |=> $stable(tsel_q) && $stable(rsten_q) && $stable(en_q) && $stable(run_q)); // R10
  AST_LOCK_DSEL: assert property (@(posedge clk) disable iff (!rst_n) (!prot_open_i && !rst_req_i) |=> $stable(dsel_q)); // R10
  AST_WAKE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) wake_o |-> wkf_q && if_q); // R7

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wd_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              prot_open,
  input  logic              dbg_halt,
  input  logic [2:0]        force_cfg,
  output logic              irq_o,
  output logic              wake_o,
  output logic              rst_req_o
);

  wd_ctl_t    ctl;
  logic [1:0] dsel;
  logic       restart, tmo, rreq;

  wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (reg_addr),
    .we_i        (reg_we),
    .wdata_i     (reg_wdata),
    .prot_open_i (prot_open),
    .force_cfg_i (force_cfg),
    .tmo_i       (tmo),
    .rst_req_i   (rreq),
    .rdata_o     (reg_rdata),
    .restart_o   (restart),
    .ctl_o       (ctl),
    .dsel_o      (dsel),
    .irq_o       (irq_o),
    .wake_o      (wake_o)
  );

  wdog_counter u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (wd_tick),
    .dbg_halt_i (dbg_halt),
    .restart_i  (restart),
    .ctl_i      (ctl),
    .dsel_i     (dsel),
    .tmo_o      (tmo),
    .rst_req_o  (rreq)
  );

  assign rst_req_o = rreq;

  AST_IRQ_NEEDS_TMO: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_o) |-> $past(tmo) || $past(reg_we)); // R3

endmodule

// File: tb/wdog_top_bench.sv
module wdog_top_bench;

  localparam logic [31:0] B_RS  = 32'h1;
  localparam logic [31:0] B_RE  = 32'h2;
  localparam logic [31:0] B_RF  = 32'h4;
  localparam logic [31:0] B_IF  = 32'h8;
  localparam logic [31:0] B_WE  = 32'h10;
  localparam logic [31:0] B_WF  = 32'h20;
  localparam logic [31:0] B_IE  = 32'h40;
  localparam logic [31:0] B_EN  = 32'h80;
  localparam logic [31:0] B_DR  = 32'h8000_0000;
  localparam logic [31:0] W1C   = 32'h2C;

  logic        clk, rst_n, wd_tick, reg_we, prot_open, dbg_halt;
  logic [2:0]  reg_addr, force_cfg;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_o, wake_o, rst_req_o;
  int          checks, errs, n_rst, n_wake;
  logic [31:0] v, v2;

  wdog_top u_wdog_top (
    .clk(clk), .rst_n(rst_n), .wd_tick(wd_tick), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .prot_open(prot_open), .dbg_halt(dbg_halt), .force_cfg(force_cfg),
    .irq_o(irq_o), .wake_o(wake_o), .rst_req_o(rst_req_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && rst_req_o) n_rst <= n_rst + 1;
    if (rst_n && wake_o)    n_wake <= n_wake + 1;
  end

  function automatic int lim_f(input int k);
    return 1 << (4 + 2 * k);
  endfunction

  function automatic int dly_f(input int k);
    case (k)
      0: return 1026;
      1: return 130;
      2: return 18;
      default: return 3;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic u);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1; prot_open = u;
    @(negedge clk);
    reg_we = 1'b0; prot_open = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      wd_tick = 1'b1;
      @(negedge clk);
      wd_tick = 1'b0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic start(input int ts, input int ds, input logic [31:0] extra);
    wr(3'd4, 32'(ds), 1'b1);
    wr(3'd0, B_EN | extra | (32'(ts) << 8) | B_RS | W1C, 1'b1);
  endtask

  task automatic flag_if(input string req, input logic exp);
    logic [31:0] r;
    rd(3'd0, r);
    chk(req, {31'd0, r[3]}, {31'd0, exp});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n0, w0;
    void'($urandom(32'd2024));
    checks = 0; errs = 0; n_rst = 0; n_wake = 0;
    rst_n = 1'b0; wd_tick = 1'b0; reg_we = 1'b0; prot_open = 1'b0;
    dbg_halt = 1'b0; force_cfg = 3'b111; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(3'd0, v); chk("R11 ctrl after reset", v, 32'h0);
    rd(3'd4, v); chk("R11 alt after reset", v, 32'h0);
    chk("R11 outputs after reset", {29'd0, irq_o, wake_o, rst_req_o}, 32'h0);

    // R11 unused bits and addresses
    wr(3'd0, 32'hFFFF_FFFF, 1'b1);
    rd(3'd0, v); chk("R11 ctrl readable bits", v, 32'h8000_07D2);
    wr(3'd4, 32'hFFFF_FFFF, 1'b1);
    rd(3'd4, v); chk("R11 alt readable bits", v, 32'h3);
    rd(3'd2, v); chk("R11 unmapped address", v, 32'h0);

    // R2 interval boundaries, R1 restart
    start(0, 3, 0);
    rd(3'd0, v); chk("R1 restart bit reads 0", {31'd0, v[0]}, 32'h0);
    ticks(15); flag_if("R2 code0 before limit", 1'b0);
    ticks(1);  flag_if("R2 code0 at limit", 1'b1);
    start(2, 3, 0);
    ticks(255); flag_if("R2 code2 before limit", 1'b0);
    ticks(1);   flag_if("R2 code2 at limit", 1'b1);
    start(0, 3, 0);
    ticks(12); wr(3'd0, B_EN | B_RS, 1'b1);
    ticks(15); flag_if("R1 restart mid-count", 1'b0);
    ticks(1);  flag_if("R1 time-out after restart", 1'b1);

    // R3 interrupt gating, R6 flag clearing
    chk("R3 irq low with enable off", {31'd0, irq_o}, 32'h0);
    wr(3'd0, B_EN | B_IE, 1'b1);
    #1 chk("R3 irq high with enable on", {31'd0, irq_o}, 32'h1);
    wr(3'd0, 32'h0, 1'b0);
    flag_if("R6 writing 0 keeps flag", 1'b1);
    wr(3'd0, B_IF, 1'b0);
    flag_if("R6 W1C time-out flag", 1'b0);
    #1 chk("R3 irq falls with flag", {31'd0, irq_o}, 32'h0);

    // R4 grace window and R5 consequences
    start(0, 3, B_RE);
    n0 = n_rst;
    ticks(16); ticks(2); settle();
    chk("R4 no pulse before window end", 32'(n_rst), 32'(n0));
    ticks(1); settle();
    chk("R4 single pulse at window end", 32'(n_rst), 32'(n0 + 1));
    rd(3'd0, v); chk("R5 reset flag set", {31'd0, v[2]}, 32'h1);
    rd(3'd4, v); chk("R5 grace field back to 0", v, 32'h0);
    wr(3'd0, B_IF, 1'b0);
    ticks(15); flag_if("R5 count restarted", 1'b0);
    ticks(1);  flag_if("R5 time-out after reset", 1'b1);
    wr(3'd0, B_RF, 1'b0);
    rd(3'd0, v); chk("R6 W1C reset flag", {31'd0, v[2]}, 32'h0);

    start(0, 2, B_RE);
    n0 = n_rst;
    ticks(16); ticks(10);
    wr(3'd0, B_EN | B_RE | B_RS, 1'b1);
    ticks(15); settle();
    chk("R4 restart in window blocks reset", 32'(n_rst), 32'(n0));
    start(0, 3, 0);
    ticks(24); settle();
    chk("R4 reset disabled gives no pulse", 32'(n_rst), 32'(n0));

    // R7 wake
    start(0, 3, B_WE | B_IE);
    w0 = n_wake;
    ticks(16); settle();
    chk("R7 wake pulse", 32'(n_wake), 32'(w0 + 1));
    rd(3'd0, v); chk("R7 wake flag set", {31'd0, v[5]}, 32'h1);
    wr(3'd0, B_WF, 1'b0);
    rd(3'd0, v); chk("R6 wake flag locked clear", {31'd0, v[5]}, 32'h1);
    wr(3'd0, B_EN | B_WF, 1'b1);
    rd(3'd0, v); chk("R6 wake flag unlocked clear", {31'd0, v[5]}, 32'h0);
    start(0, 3, B_WE);
    w0 = n_wake;
    ticks(16); settle();
    chk("R7 no wake without irq enable", 32'(n_wake), 32'(w0));
    rd(3'd0, v); chk("R7 wake flag stays 0", {31'd0, v[5]}, 32'h0);

    // R8 enable and forced enable
    start(0, 3, 0);
    ticks(10);
    wr(3'd0, 32'h0, 1'b1);
    ticks(40); flag_if("R8 disabled no time-out", 1'b0);
    wr(3'd0, B_EN, 1'b1);
    ticks(15); flag_if("R8 counter cleared by disable", 1'b0);
    ticks(1);  flag_if("R8 runs after re-enable", 1'b1);
    force_cfg = 3'b010;
    wr(3'd0, W1C, 1'b1);
    rd(3'd0, v); chk("R8 forced enable reads 1", {31'd0, v[7]}, 32'h1);
    wr(3'd0, B_RS, 1'b1);
    ticks(16); flag_if("R8 forced enable counts", 1'b1);
    force_cfg = 3'b111;
    rd(3'd0, v); chk("R8 stored enable shows 0", {31'd0, v[7]}, 32'h0);

    // R9 debug halt
    start(0, 3, 0);
    ticks(10);
    dbg_halt = 1'b1; ticks(20); dbg_halt = 1'b0;
    ticks(5); flag_if("R9 halt pauses count", 1'b0);
    ticks(1); flag_if("R9 count resumes", 1'b1);
    start(0, 3, B_DR);
    dbg_halt = 1'b1; ticks(16); dbg_halt = 1'b0;
    flag_if("R9 run-in-debug keeps counting", 1'b1);

    // R10 lock
    start(1, 1, B_RE | B_IE);
    for (int i = 0; i < 6; i++) begin
      rd(3'd0, v);
      wr(3'd0, $urandom() & ~W1C, 1'b0);
      rd(3'd0, v2); chk("R10 ctrl locked", v2, v);
      rd(3'd4, v);
      wr(3'd4, $urandom(), 1'b0);
      rd(3'd4, v2); chk("R10 grace field locked", v2, v);
    end
    start(1, 1, 0);
    ticks(60);
    wr(3'd0, B_RS, 1'b0);
    ticks(4); flag_if("R10 locked restart ignored", 1'b1);

    // constrained random sweep
    for (int it = 0; it < 16; it++) begin
      int ts, ds, re, sv, k;
      ts = $urandom_range(0, 3); ds = $urandom_range(0, 3);
      re = $urandom_range(0, 1); sv = $urandom_range(0, 1);
      start(ts, ds, re != 0 ? B_RE : 32'h0);
      n0 = n_rst;
      ticks(lim_f(ts) - 1); flag_if("R2 random before limit", 1'b0);
      ticks(1);             flag_if("R2 random at limit", 1'b1);
      if (sv != 0) begin
        k = $urandom_range(0, dly_f(ds) - 1);
        ticks(k);
        wr(3'd0, B_EN | (re != 0 ? B_RE : 32'h0) | (32'(ts) << 8) | B_RS, 1'b1);
        settle();
        chk("R4 random restart in window", 32'(n_rst), 32'(n0));
      end else begin
        ticks(dly_f(ds)); settle();
        chk("R4 random window end", 32'(n_rst), 32'(n0 + re));
        rd(3'd0, v); chk("R5 random reset flag", {31'd0, v[2]}, 32'(re));
      end
    end

    finish_run();
  end

endmodule